// File: doc/BRIEF.md
# Clocked Sequence Recognizer

This block watches boolean event inputs on a sampled clock and raises a one-cycle hit whenever a fixed temporal pattern has just completed. The pattern is: event A, then a cycle gap chosen from a parameterised range, then event B held for a consecutive run whose length falls in a second parameterised range. A qualifier input must stay high for the whole stretch, from A through the last B. Either range may be left open at the top. An optional trailing clock step delays the hit by one cycle, for use as the antecedent of a next-cycle implication.

The recognizer is a nondeterministic automaton. Each node of the pattern is a separate flop that starts at 0, and any number of nodes may be live at once, so overlapping attempts are tracked side by side without counters. A node is reached either by a clocked step from its predecessor or by a same-cycle bypass. Optional gap cycles and optional repeats are both built from these bypasses. A start input opens a new attempt; tie it high to try from every cycle. A kill input clears every live node in the cycle it is asserted.

Top module: `seqrec_top`

## Requirements
- R1: While `rst_n` is low, all node flops clear to 0. With idle inputs, `hit_o` stays low during reset and in the first cycles after it.
- R2: An attempt begins only in a cycle where `start_i`, `evt_a_i` and `hold_i` are all high. With `start_i` low, a pattern that would otherwise match gives no hit.
- R3: Let the cycle in which A is sampled be offset 0. The first B of the run must fall at an offset from `DLY_MIN` to `DLY_MAX` inclusive. When `DLY_OPEN` is nonzero there is no upper limit.
- R4: B must be high on a run of consecutive cycles whose count is between `REP_MIN` and `REP_MAX` inclusive (no upper limit when `REP_OPEN` is nonzero). Every count in that range that completes produces a hit.
- R5: `hold_i` must be high in every cycle from A through the last B. A single low cycle drops the attempt.
- R6: In any cycle with `kill_i` high, every live attempt is discarded and `hit_o` is low.
- R7: Overlapping attempts are tracked independently. `hit_o` is high whenever at least one of them completes.
- R8: With `POST_STEP` = 0, `hit_o` is high in the same cycle as the last B of a completed run, driven combinationally from that cycle's inputs.
- R9: With `POST_STEP` nonzero, the hit comes one cycle after the last B. It is still forced low if `kill_i` is high in that later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all node flops |
| start_i | input | 1 | Opens a new attempt in this cycle |
| kill_i | input | 1 | Clears every live node in this cycle |
| evt_a_i | input | 1 | Leading event of the pattern |
| evt_b_i | input | 1 | Repeated trailing event |
| hold_i | input | 1 | Qualifier that must hold across the whole match |
| hit_o | output | 1 | One-cycle pulse when a match completes |

## Verification
Two events often land in the same cycle: a completion, and a kill or a qualifier drop that belongs to an attempt still in progress. A second attempt starting while the first is partway through also overlaps with it. Directed stimulus places a kill exactly on the completing cycle and places a second A inside the gap of the first. A long stretch of random events with occasional kills and qualifier drops then follows. Both an immediate-hit instance and a trailing-step instance are judged every cycle. The reference is a declarative search over the recorded input history for any start, gap and run length that satisfy the stated ranges.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;

    // Highest node index of a range chain: an open range stops at its
    // lower bound and closes with a loop, a bounded one runs to its upper bound.
    function automatic int span_top(input int lo, input int hi, input int open);
        return (open != 0) ? lo : hi;
    endfunction

endpackage

// File: rtl/seqrec_delay.sv
module seqrec_delay #(
    parameter int LO   = 1,
    parameter int HI   = 3,
    parameter int OPEN = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic hold,
    input  logic enter,
    output logic leave
);
    localparam int TOP = seqrec_pkg::span_top(LO, HI, OPEN);

    logic [TOP:0] node_q;
    logic [TOP:0] node_d;
    logic [TOP:0] live;

    // Effective node values; indices above LO also take a same-cycle bypass.
    always_comb begin
        for (int k = 0; k <= TOP; k++) begin
            live[k] = node_q[k] & ~kill;
            if (k == 0)
                live[k] = live[k] | enter;
            else if (k > LO)
                live[k] = live[k] | (live[k-1] & hold);
        end
    end

    // Clocked steps along the chain, plus the self-loop of an open range.
    always_comb begin
        node_d = '0;
        for (int k = 1; k <= TOP; k++)
            node_d[k] = live[k-1] & hold;
        if (OPEN != 0)
            node_d[TOP] = node_d[TOP] | (live[TOP] & hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) node_q <= '0;
        else        node_q <= node_d;
    end

    assign leave = live[TOP];

endmodule

// File: rtl/seqrec_repeat.sv
module seqrec_repeat #(
    parameter int LO   = 2,
    parameter int HI   = 3,
    parameter int OPEN = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic hold,
    input  logic bit_i,
    input  logic enter,
    output logic leave
);
    localparam int TOP = seqrec_pkg::span_top(LO, HI, OPEN);

    // gap_q[c] (c >= 1) sits between copy c-1 and copy c; gap_q[0] is the loop-back flop.
    logic [TOP-1:0] gap_q;
    logic [TOP-1:0] gap_d;
    logic [TOP-1:0] copy_ok;
    logic           loop_hit;
    logic           done;

    always_comb begin
        copy_ok[0] = enter & bit_i & hold;
        for (int c = 1; c < TOP; c++) begin
            copy_ok[c] = gap_q[c] & ~kill & bit_i & hold;
            if (c >= LO)
                copy_ok[c] = copy_ok[c] | (copy_ok[c-1] & hold);
        end
        loop_hit = gap_q[0] & ~kill & bit_i & hold;
        done     = (OPEN != 0) ? (copy_ok[TOP-1] | loop_hit) : copy_ok[TOP-1];
    end

    always_comb begin
        gap_d = '0;
        for (int c = 1; c < TOP; c++)
            gap_d[c] = copy_ok[c-1] & hold;
        if (OPEN != 0)
            gap_d[0] = done & hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign leave = done;

endmodule

// File: rtl/seqrec_top.sv
module seqrec_top #(
    parameter int DLY_MIN   = 1,
    parameter int DLY_MAX   = 3,
    parameter int DLY_OPEN  = 0,
    parameter int REP_MIN   = 2,
    parameter int REP_MAX   = 3,
    parameter int REP_OPEN  = 0,
    parameter int POST_STEP = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic kill_i,
    input  logic evt_a_i,
    input  logic evt_b_i,
    input  logic hold_i,
    output logic hit_o
);
    logic seed_live;
    logic a_live;
    logic gap_done;
    logic run_done;

    assign seed_live = start_i & ~kill_i;
    assign a_live    = seed_live & evt_a_i & hold_i;

    seqrec_delay #(.LO(DLY_MIN), .HI(DLY_MAX), .OPEN(DLY_OPEN)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .kill  (kill_i),
        .hold  (hold_i),
        .enter (a_live),
        .leave (gap_done)
    );

    seqrec_repeat #(.LO(REP_MIN), .HI(REP_MAX), .OPEN(REP_OPEN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .kill  (kill_i),
        .hold  (hold_i),
        .bit_i (evt_b_i),
        .enter (gap_done),
        .leave (run_done)
    );

    generate
        if (POST_STEP != 0) begin : g_post
            logic post_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) post_q <= 1'b0;
                else        post_q <= run_done;
            end
            assign hit_o = post_q & ~kill_i;
        end else begin : g_direct
            assign hit_o = run_done;
        end
    endgenerate

endmodule

// File: rtl/seqrec_chk.sv
module seqrec_chk #(
    parameter int DLY_MIN   = 1,
    parameter int REP_MIN   = 2,
    parameter int POST_STEP = 0
) (
    input logic clk,
    input logic rst_n,
    input logic kill_i,
    input logic evt_b_i,
    input logic hold_i,
    input logic hit_o
);
    assert_kill_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |-> !hit_o);

    generate
        if (POST_STEP != 0 || DLY_MIN + REP_MIN > 1) begin : g_quiet
            assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> !hit_o);
        end
        if (POST_STEP == 0) begin : g_now
            assert_hold_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> hold_i);
            assert_b_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> evt_b_i);
        end else begin : g_late
            assert_b_before_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> $past(evt_b_i && hold_i));
        end
    endgenerate
endmodule

bind seqrec_top seqrec_chk #(
    .DLY_MIN   (DLY_MIN),
    .REP_MIN   (REP_MIN),
    .POST_STEP (POST_STEP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill_i  (kill_i),
    .evt_b_i (evt_b_i),
    .hold_i  (hold_i),
    .hit_o   (hit_o)
);

// File: tb/seqrec_top_tb.sv
module seqrec_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DMIN = 1;
    localparam int DMAX = 3;
    localparam int RMIN = 2;
    localparam int RMAX = 3;
    localparam int HIST = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, kill_i = 1'b0, evt_a_i = 1'b0, evt_b_i = 1'b0, hold_i = 1'b1;
    logic hit_now, hit_late;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqrec_top #(.DLY_MIN(DMIN), .DLY_MAX(DMAX), .DLY_OPEN(0),
                 .REP_MIN(RMIN), .REP_MAX(RMAX), .REP_OPEN(0), .POST_STEP(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kill_i(kill_i),
        .evt_a_i(evt_a_i), .evt_b_i(evt_b_i), .hold_i(hold_i), .hit_o(hit_now));

    seqrec_top #(.DLY_MIN(DMIN), .DLY_MAX(DMAX), .DLY_OPEN(0),
                 .REP_MIN(RMIN), .REP_MAX(RMAX), .REP_OPEN(0), .POST_STEP(1)) u_dut_post (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kill_i(kill_i),
        .evt_a_i(evt_a_i), .evt_b_i(evt_b_i), .hold_i(hold_i), .hit_o(hit_late));

    typedef struct {
        string tag;
        logic  exp_now;
        logic  exp_late;
    } item_t;

    item_t sb_q[$];
    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;
    logic h_t[HIST], h_k[HIST], h_a[HIST], h_b[HIST], h_q[HIST];

    // Declarative reference: any start, gap and run length inside the ranges.
    function automatic logic model(int t, int post);
        logic found = 1'b0;
        for (int s = t; s >= 0 && s >= t - 12; s--) begin
            if (h_t[s] && h_a[s]) begin
                for (int d = DMIN; d <= DMAX; d++) begin
                    for (int n = RMIN; n <= RMAX; n++) begin
                        if (s + d + n - 1 + post == t) begin
                            logic ok = 1'b1;
                            for (int c = s; c <= t; c++) if (h_k[c]) ok = 1'b0;
                            for (int c = s; c <= s + d + n - 1; c++) if (!h_q[c]) ok = 1'b0;
                            for (int c = s + d; c <= s + d + n - 1; c++) if (!h_b[c]) ok = 1'b0;
                            if (ok) found = 1'b1;
                        end
                    end
                end
            end
        end
        return found;
    endfunction

    task automatic step(string tag, logic tr, logic a, logic b, logic q, logic k);
        item_t it;
        @(negedge clk);
        start_i = tr; evt_a_i = a; evt_b_i = b; hold_i = q; kill_i = k;
        h_t[cyc] = tr; h_a[cyc] = a; h_b[cyc] = b; h_q[cyc] = q; h_k[cyc] = k;
        it.tag = tag;
        it.exp_now = model(cyc, 0);
        it.exp_late = model(cyc, 1);
        sb_q.push_back(it);
        cyc++;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    // Monitor: pops one expected item per cycle, away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (hit_now !== it.exp_now) begin
                n_fail++;
                $display("FAIL %s R8 cycle %0d: hit=%b expected %b", it.tag, cyc - 1, hit_now, it.exp_now);
            end
            n_run++;
            if (hit_late !== it.exp_late) begin
                n_fail++;
                $display("FAIL %s R9 cycle %0d: hit=%b expected %b", it.tag, cyc - 1, hit_late, it.exp_late);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        n_run++;
        if (hit_now !== 1'b0 || hit_late !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: hit=%b/%b expected 0/0", hit_now, hit_late);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1", 3);

        // R3: gap of 1, run of 2
        step("R3", 1, 1, 0, 1, 0); step("R3", 1, 0, 1, 1, 0); step("R3", 1, 0, 1, 1, 0);
        idle("R3", 4);
        // R3: gap of 3 (accepted), then gap of 4 (rejected)
        step("R3", 1, 1, 0, 1, 0); idle("R3", 2);
        step("R3", 1, 0, 1, 1, 0); step("R3", 1, 0, 1, 1, 0); idle("R3", 4);
        step("R3", 1, 1, 0, 1, 0); idle("R3", 3);
        step("R3", 1, 0, 1, 1, 0); step("R3", 1, 0, 1, 1, 0); idle("R3", 4);

        // R4: run of 1 rejected, run of 4 hits for each valid count
        step("R4", 1, 1, 0, 1, 0); step("R4", 1, 0, 1, 1, 0); idle("R4", 4);
        step("R4", 1, 1, 0, 1, 0);
        for (int i = 0; i < 4; i++) step("R4", 1, 0, 1, 1, 0);
        idle("R4", 4);

        // R2: no start, no hit
        step("R2", 0, 1, 0, 1, 0); step("R2", 0, 0, 1, 1, 0); step("R2", 0, 0, 1, 1, 0);
        idle("R2", 4);

        // R5: qualifier drop mid-run, and in the gap
        step("R5", 1, 1, 0, 1, 0); step("R5", 1, 0, 1, 0, 0); step("R5", 1, 0, 1, 1, 0);
        idle("R5", 4);
        step("R5", 1, 1, 0, 1, 0); step("R5", 1, 0, 0, 0, 0);
        step("R5", 1, 0, 1, 1, 0); step("R5", 1, 0, 1, 1, 0); idle("R5", 4);

        // R6: kill on the completing cycle, then kill inside the gap
        step("R6", 1, 1, 0, 1, 0); step("R6", 1, 0, 1, 1, 0); step("R6", 1, 0, 1, 1, 1);
        idle("R6", 4);
        step("R6", 1, 1, 0, 1, 0); step("R6", 1, 0, 0, 1, 1);
        step("R6", 1, 0, 1, 1, 0); step("R6", 1, 0, 1, 1, 0); idle("R6", 4);
        // R9: kill in the cycle after the last B only
        step("R9", 1, 1, 0, 1, 0); step("R9", 1, 0, 1, 1, 0); step("R9", 1, 0, 1, 1, 0);
        step("R9", 1, 0, 0, 1, 1); idle("R9", 4);

        // R7: second A arrives while the first attempt is in its gap
        step("R7", 1, 1, 0, 1, 0); step("R7", 1, 1, 0, 1, 0);
        step("R7", 1, 0, 1, 1, 0); step("R7", 1, 0, 1, 1, 0); step("R7", 1, 0, 1, 1, 0);
        idle("R7", 4);

        // R7: random mix of overlapping attempts, kills and qualifier drops
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            step("R7", (r[3:0] != 0), r[4], r[5] | r[6], (r[9:7] != 0), (r[13:10] == 0));
        end
        idle("R7", 8);

        @(negedge clk);
        #5;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule